// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a record of which on-chip reset sources have fired since the last cold start. Each of seven internal sources drives a one-cycle event pulse: flash standby, trimming-data status, trimming-data reset, two voltage-detect levels, system clock fault and watchdog. Each pulse sets its own sticky flag. Software reads the flags through a byte-wide register bus at one status address. The flags are meant to be read after the chip comes back from an internal reset, so that reset does not touch them. Only the cold reset input clears them, and that input covers power-on and the external reset pin.

Software can also clear the flags itself, but only in two guarded steps. First it writes a 1 to the top bit of the status byte, which arms the clear. Then it writes the key byte 0x71 to a separate key address. The second write empties all seven flags and drops the arm bit again. Any other key value changes nothing. A correct key written while the clear is not armed also changes nothing. If a source fires in the same cycle as a clear, the source wins.

Top module: `rstCauseReg`

## Requirements
- R1: A read at STAT_ADDR returns {1'b0, flags} with watchdog in bit 0, system clock in bit 1, voltage-detect 1 in bit 2, voltage-detect 2 in bit 3, trimming reset in bit 4, trimming status in bit 5 and flash standby in bit 6. A read at any other address returns 0x00.
- R2: Bit 7 of the status read is always 0, even while the clear is armed.
- R3: While coldRstN is low, all flags and the arm bit are 0, without waiting for a clock edge.
- R4: An event pulse on evtPulse[i] in one cycle makes flag i read 1 after that clock edge. The flag then stays 1 until a clear.
- R5: warmRst clears the arm bit at the next edge and leaves every flag unchanged.
- R6: A write to STAT_ADDR loads data bit 7 into the arm bit. Data bits 6..0 of that write have no effect on the flags.
- R7: If the arm bit is 1, a write of 0x71 to KEY_ADDR clears all seven flags and the arm bit at the same edge.
- R8: A key write of any value other than 0x71 changes neither the flags nor the arm bit. A 0x71 key write while the arm bit is 0 has no effect.
- R9: If an event pulse arrives in the same cycle as a keyed clear, that flag is 1 after the edge and the other flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Asynchronous active-low cold reset (power-on or external pin) |
| warmRst | input | 1 | Synchronous internal-source reset; clears only the arm bit |
| evtPulse | input | NUM_SRC (7) | One-cycle event pulses, one per reset source, in the R1 bit order |
| busWrEn | input | 1 | Register-bus write strobe |
| busAddr | input | ADDR_W (12) | Register-bus address |
| busWrData | input | 8 | Register-bus write data |
| busRdData | output | 8 | Register-bus read data for busAddr |

## Verification
The bench starts with directed sequences. These cover a single event per source, which separates the bit positions. They also cover an arm followed by the correct key, the wrong key, and the correct key without arming, which separates a guarded clear from an open one. A clear with an event in the same cycle shows whether the event takes priority. A warm reset between arming and the key write shows that warm resets are kept apart from cold resets. After that, a seeded random mix of sparse pulses, status writes, key writes with random or correct values, and warm resets runs against a reference model in the bench. That run reaches interleavings, such as repeated arming and a stale arm, that the directed cases do not cover.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  // Strobes from the control module to the flag datapath.
  typedef struct packed {
    logic flagClr;   // keyed clear accepted this cycle
    logic statSel;   // bus address selects the status byte
  } rcrStrobe_t;
endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 'h0A0,
  parameter int KEY_ADDR  = 'h0A4,
  parameter int KEY_VALUE = 'h71
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              armBit,
  output rcrStrobe_t        strobe
);
  localparam int ARM_POS = DATA_W - 1;

  logic statHit, keyHit, keyMatch, statWr;

  always_comb begin
    statHit  = (busAddr == ADDR_W'(STAT_ADDR));
    keyHit   = (busAddr == ADDR_W'(KEY_ADDR));
    keyMatch = (busWrData == DATA_W'(KEY_VALUE));
    statWr   = busWrEn && statHit;
    strobe.statSel = statHit;
    strobe.flagClr = armBit && busWrEn && keyHit && keyMatch;
  end

  // Arm bit: reset by cold and warm resets; self-clears on an accepted key.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)          armBit <= 1'b0;
    else if (warmRst)       armBit <= 1'b0;
    else if (strobe.flagClr) armBit <= 1'b0;
    else if (statWr)        armBit <= busWrData[ARM_POS];
  end
endmodule

// File: rtl/rcr_flags.sv
module rcr_flags
  import rcr_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  rcrStrobe_t         strobe,
  output logic [NUM_SRC-1:0] flagVec,
  output logic [DATA_W-1:0]  rdData
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  // One sticky cell per source; the event outranks the clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    always_ff @(posedge clk or negedge coldRstN) begin
      if (!coldRstN)           flagVec[i] <= 1'b0;
      else if (evtPulse[i])    flagVec[i] <= 1'b1;
      else if (strobe.flagClr) flagVec[i] <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.statSel) rdData = {{PAD_W{1'b0}}, flagVec};
  end
endmodule

// File: rtl/rstCauseReg.sv
module rstCauseReg
  import rcr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SRC   = 7,
  parameter int STAT_ADDR = 'h0A0,
  parameter int KEY_ADDR  = 'h0A4,
  parameter int KEY_VALUE = 'h71,
  localparam int DATA_W   = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  logic               warmRst,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData
);
  rcrStrobe_t         strobe;
  logic               armBit;
  logic [NUM_SRC-1:0] flagVec;

  rcr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .KEY_ADDR(KEY_ADDR), .KEY_VALUE(KEY_VALUE)
  ) u_ctrl (
    .clk(clk), .coldRstN(coldRstN), .warmRst(warmRst),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .armBit(armBit), .strobe(strobe)
  );

  rcr_flags #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .coldRstN(coldRstN), .evtPulse(evtPulse),
    .strobe(strobe), .flagVec(flagVec), .rdData(busRdData)
  );
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_SRC   = 7,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 'h0A0,
  parameter int KEY_ADDR  = 'h0A4,
  parameter int KEY_VALUE = 'h71
) (
  input logic               clk,
  input logic               coldRstN,
  input logic               warmRst,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [DATA_W-1:0]  busRdData,
  input logic [NUM_SRC-1:0] flagVec,
  input logic               armBit
);
  logic goodKey, anyKey;
  assign anyKey  = busWrEn && (busAddr == ADDR_W'(KEY_ADDR));
  assign goodKey = anyKey && (busWrData == DATA_W'(KEY_VALUE));

  // R2: top bit never reads as 1
  a_r2_top_zero: assert property (@(posedge clk) disable iff (!coldRstN)
    busRdData[DATA_W-1] == 1'b0);

  // R4: event pulse sets its flag
  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!coldRstN)
    (evtPulse != '0) |=> ((flagVec & $past(evtPulse)) == $past(evtPulse)));

  // R5: warm reset drops the arm bit
  a_r5_warm_disarms: assert property (@(posedge clk) disable iff (!coldRstN)
    warmRst |=> !armBit);

  // R7, R9: accepted clear leaves only same-cycle events
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!coldRstN)
    (armBit && goodKey) |=> (flagVec == $past(evtPulse)) && !armBit);

  // R8: any key write without acceptance changes nothing
  a_r8_bad_key: assert property (@(posedge clk) disable iff (!coldRstN)
    (anyKey && !(armBit && goodKey) && !warmRst && evtPulse == '0)
      |=> (flagVec == $past(flagVec)) && (armBit == $past(armBit)));

  // R6: flags only move on an event or an accepted clear
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!coldRstN)
    (evtPulse == '0 && !(armBit && goodKey)) |=> $stable(flagVec));
endmodule

bind rstCauseReg rcr_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
  .STAT_ADDR(STAT_ADDR), .KEY_ADDR(KEY_ADDR), .KEY_VALUE(KEY_VALUE)
) u_chk (
  .clk(clk), .coldRstN(coldRstN), .warmRst(warmRst), .evtPulse(evtPulse),
  .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .busRdData(busRdData), .flagVec(flagVec), .armBit(armBit)
);

// File: tb/sim_rstCauseReg.sv
`timescale 1ns/1ps
module sim_rstCauseReg;
  localparam int AW = 12;
  localparam logic [AW-1:0] STAT = 12'h0A0;
  localparam logic [AW-1:0] KEY  = 12'h0A4;

  logic clk = 0, coldRstN = 0, warmRst = 0, busWrEn = 0;
  logic [6:0] evtPulse = '0;
  logic [AW-1:0] busAddr = STAT;
  logic [7:0] busWrData = '0, busRdData;

  int checks = 0, errors = 0;
  logic [6:0] expFlags = '0;
  logic expArm = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rstCauseReg u0 (.clk(clk), .coldRstN(coldRstN), .warmRst(warmRst),
    .evtPulse(evtPulse), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData));

  function automatic logic [6:0] nxtFlags(logic [6:0] f, logic a, logic [6:0] e,
      logic w, logic [AW-1:0] ad, logic [7:0] d);
    logic clr = a && w && ad == KEY && d == 8'h71;
    return (clr ? 7'h0 : f) | e;
  endfunction

  function automatic logic nxtArm(logic a, logic wr, logic w, logic [AW-1:0] ad, logic [7:0] d);
    if (wr) return 1'b0;
    if (a && w && ad == KEY && d == 8'h71) return 1'b0;
    if (w && ad == STAT) return d[7];
    return a;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  // One cycle of stimulus, then a status read checked against the model.
  task automatic step(string req, logic [6:0] e, logic w, logic [AW-1:0] ad,
      logic [7:0] d, logic wr);
    logic [6:0] nf;
    logic na;
    @(negedge clk);
    evtPulse = e; busWrEn = w; busAddr = ad; busWrData = d; warmRst = wr;
    nf = nxtFlags(expFlags, expArm, e, w, ad, d);
    na = nxtArm(expArm, wr, w, ad, d);
    @(posedge clk);
    expFlags = nf; expArm = na;
    #1;
    evtPulse = '0; busWrEn = 0; busAddr = STAT; warmRst = 0;
    #0.5;
    chk(req, busRdData, {1'b0, expFlags});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    process::self().srandom(32'h5EED1234);
    #1;
    chk("R3 reset read", busRdData, 8'h00);
    @(negedge clk); coldRstN = 1;

    // R4 / R1: each source lands in its own bit position
    for (int i = 0; i < 7; i++) step("R4 R1 single event", 7'(1 << i), 0, STAT, 0, 0);
    // R1: other address reads zero
    @(negedge clk); busAddr = 12'h0A8; #0.5;
    chk("R1 other addr", busRdData, 8'h00);
    busAddr = STAT;
    // R2: armed, top bit still reads 0
    step("R2 R6 arm write ignores low bits", 0, 1, STAT, 8'h80, 0);
    // R8: wrong key while armed
    step("R8 wrong key", 0, 1, KEY, 8'h70, 0);
    // R7: correct key clears
    step("R7 keyed clear", 0, 1, KEY, 8'h71, 0);
    step("R4 set after clear", 7'h12, 0, STAT, 0, 0);
    // R8: arm already auto-dropped, key again does nothing
    step("R8 key unarmed", 0, 1, KEY, 8'h71, 0);
    // R5: warm reset keeps flags, kills arm
    step("R6 arm", 0, 1, STAT, 8'h80, 0);
    step("R5 warm reset", 0, 0, STAT, 0, 1);
    step("R5 key after warm", 0, 1, KEY, 8'h71, 0);
    // R6: write of 0 disarms
    step("R6 arm", 0, 1, STAT, 8'hFF, 0);
    step("R6 disarm", 0, 1, STAT, 8'h00, 0);
    step("R6 key after disarm", 0, 1, KEY, 8'h71, 0);
    // R9: event and clear in the same cycle
    step("R6 arm", 7'h01, 1, STAT, 8'h80, 0);
    step("R9 event beats clear", 7'h40, 1, KEY, 8'h71, 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [6:0] e = ($urandom_range(0, 3) == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h0;
      case (op)
        0, 1: step("R6 rand status write", e, 1, STAT, 8'($urandom), 0);
        2:    step("R8 rand key", e, 1, KEY, 8'($urandom), 0);
        3, 4: step("R7 rand good key", e, 1, KEY, 8'h71, 0);
        5:    step("R5 rand warm", e, 0, STAT, 0, 1);
        6:    step("R6 rand arm", e, 1, STAT, 8'h80, 0);
        default: step("R4 rand idle", e, 0, STAT, 0, 0);
      endcase
    end

    // R3: cold reset mid-run, asynchronous
    step("R4 fill", 7'h7F, 0, STAT, 0, 0);
    @(negedge clk); coldRstN = 0; #1;
    chk("R3 async cold clear", busRdData, 8'h00);
    expFlags = '0; expArm = 0;
    @(negedge clk); coldRstN = 1;
    step("R3 arm gone after cold", 0, 1, KEY, 8'h71, 0);
    finishRun();
  end
endmodule